// File: doc/BRIEF.md
# Paired Halfword Dot-Product Accumulator

This block performs one multiply-accumulate step per clock on packed data. Each 32-bit source holds two signed 16-bit lanes: lane 0 in bits 15:0 and lane 1 in bits 31:16. An operation forms two lane products and applies both to one of four 64-bit accumulators, chosen by a 2-bit index. Each product is either added to or subtracted from the accumulator.

A 5-bit sub-opcode selects the variant. The lanes can be paired straight or crossed. Products can be plain integers or Q15 fractions, which are doubled. The fractional variants can also clamp the accumulator to the signed 32-bit range. Each accumulator has its own sticky overflow flag.

A test port writes any accumulator directly and reads any accumulator back. The result of an operation is visible on the read port one clock after it is issued.

Top module: `dotacc_unit`

## Requirements
- R1: While `rst_n` is low, all four accumulators and all four overflow flags clear to zero.
- R2: Sub-opcode 00000 adds `a.lane0*b.lane0 + a.lane1*b.lane1` to the selected accumulator. Sub-opcode 00001 subtracts both of those products. All products are signed and 32 bits wide.
- R3: Sub-opcode 01000 adds `a.lane0*b.lane1 + a.lane1*b.lane0` (crossed pairing). Sub-opcode 01001 subtracts both of those products.
- R4: Sub-opcode 00010 pairs the lanes straight, subtracts the lane 0 product and adds the lane 1 product.
- R5: Sub-opcodes 11000 (add) and 11001 (subtract) use crossed pairing and double each product before applying it.
- R6: In every fractional sub-opcode, a lane pair with both operands at 0x8000 contributes 0x7FFFFFFF and sets the flag of the selected accumulator.
- R7: Sub-opcodes 11010 (add) and 11011 (subtract) behave like R5. After both products are applied, the result is clamped to the range [0xFFFFFFFF80000000, 0x000000007FFFFFFF], and the selected flag is set whenever the clamp acts.
- R8: Overflow flags are sticky, one bit per accumulator, indexed by accumulator number. Only an operation on that accumulator can set its bit.
- R9: Sub-opcodes without saturation wrap modulo 2^64 and never clamp. The integer sub-opcodes never set a flag.
- R10: Any sub-opcode not listed above leaves every accumulator and every flag unchanged.
- R11: While `tw_en` is high, the test write loads `tw_data` into accumulator `tw_sel`, and any operation in that cycle is ignored. `tr_data` always shows accumulator `tr_sel`.
- R12: An operation changes only the accumulator it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 5 | Sub-opcode |
| acc_sel | input | 2 | Target accumulator of the operation |
| src_a | input | 32 | First packed source |
| src_b | input | 32 | Second packed source |
| tw_en | input | 1 | Test write enable |
| tw_sel | input | 2 | Test write target |
| tw_data | input | 64 | Test write value |
| tr_sel | input | 2 | Test read index |
| tr_data | output | 64 | Contents of accumulator `tr_sel` |
| ovf_flags | output | 4 | Sticky overflow flag per accumulator |

## Verification
Two events are hard to reach through random operands. The first is the -1 times -1 product, which needs both lane operands at exactly 0x8000. The second is the saturation clamp, which needs an accumulator already sitting near the 32-bit limit.

The bench reaches both directly. Before each table vector it loads the target accumulator through the test write port, so every vector starts from a chosen value just inside or just outside the clamp range. The 0x8000 lanes are placed on one crossed pair first, then on both pairs at once.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
  localparam int LANE_W = 16;
  localparam int WORD_W = 2 * LANE_W;
  localparam int PROD_W = 2 * LANE_W;
  localparam int ACC_W  = 64;
  localparam int SAT_W  = 32;
  localparam int CODE_W = 5;
  localparam int LANES  = 2;

  localparam logic [CODE_W-1:0] OPC_STR_ADD = 5'b00000;
  localparam logic [CODE_W-1:0] OPC_STR_SUB = 5'b00001;
  localparam logic [CODE_W-1:0] OPC_MIXED   = 5'b00010;
  localparam logic [CODE_W-1:0] OPC_X_ADD   = 5'b01000;
  localparam logic [CODE_W-1:0] OPC_X_SUB   = 5'b01001;
  localparam logic [CODE_W-1:0] OPC_XF_ADD  = 5'b11000;
  localparam logic [CODE_W-1:0] OPC_XF_SUB  = 5'b11001;
  localparam logic [CODE_W-1:0] OPC_XFS_ADD = 5'b11010;
  localparam logic [CODE_W-1:0] OPC_XFS_SUB = 5'b11011;

  localparam logic [LANE_W-1:0] LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] PROD_MAX = {1'b0, {(PROD_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  CLIP_HI  = {{(ACC_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0]  CLIP_LO  = {{(ACC_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

  typedef struct packed {
    logic legal;
    logic crossed;
    logic frac;
    logic sat;
    logic neg_lo;
    logic neg_hi;
  } ctrl_t;

  typedef struct packed {
    logic [PROD_W-1:0] value;
    logic              pinned;
  } lane_prod_t;

  typedef struct packed {
    logic [ACC_W-1:0] value;
    logic             clipped;
  } clamp_t;

  // Signed lane product; fractional mode doubles it, pinning -1 * -1.
  function automatic lane_prod_t lane_mul(input logic [LANE_W-1:0] x,
                                          input logic [LANE_W-1:0] y,
                                          input logic frac);
    lane_prod_t r;
    logic signed [PROD_W-1:0] xs;
    logic signed [PROD_W-1:0] ys;
    logic signed [PROD_W-1:0] full;
    xs = {{(PROD_W-LANE_W){x[LANE_W-1]}}, x};
    ys = {{(PROD_W-LANE_W){y[LANE_W-1]}}, y};
    full = xs * ys;
    r.value  = full;
    r.pinned = 1'b0;
    if (frac) begin
      if (x == LANE_MIN && y == LANE_MIN) begin
        r.value  = PROD_MAX;
        r.pinned = 1'b1;
      end else begin
        r.value = full <<< 1;
      end
    end
    return r;
  endfunction

  function automatic logic [ACC_W-1:0] widen(input logic [PROD_W-1:0] p);
    return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction

  function automatic logic [ACC_W-1:0] apply_prod(input logic [ACC_W-1:0] acc,
                                                  input logic [PROD_W-1:0] p,
                                                  input logic neg);
    return neg ? (acc - widen(p)) : (acc + widen(p));
  endfunction

  // Clamp a 64-bit value into the signed 32-bit range.
  function automatic clamp_t clamp_word(input logic [ACC_W-1:0] v);
    clamp_t r;
    logic [ACC_W-SAT_W:0] upper;
    upper     = v[ACC_W-1:SAT_W-1];
    r.value   = v;
    r.clipped = 1'b0;
    if (!v[ACC_W-1] && (|upper)) begin
      r.value   = CLIP_HI;
      r.clipped = 1'b1;
    end else if (v[ACC_W-1] && !(&upper)) begin
      r.value   = CLIP_LO;
      r.clipped = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/dotacc_decode.sv
module dotacc_decode
  import dotacc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output ctrl_t             ctrl
);
  always_comb begin
    ctrl = '0;
    case (code)
      OPC_STR_ADD: ctrl.legal = 1'b1;
      OPC_STR_SUB: begin
        ctrl.legal  = 1'b1;
        ctrl.neg_lo = 1'b1;
        ctrl.neg_hi = 1'b1;
      end
      OPC_MIXED: begin
        ctrl.legal  = 1'b1;
        ctrl.neg_lo = 1'b1;
      end
      OPC_X_ADD: begin
        ctrl.legal   = 1'b1;
        ctrl.crossed = 1'b1;
      end
      OPC_X_SUB: begin
        ctrl.legal   = 1'b1;
        ctrl.crossed = 1'b1;
        ctrl.neg_lo  = 1'b1;
        ctrl.neg_hi  = 1'b1;
      end
      OPC_XF_ADD, OPC_XFS_ADD: begin
        ctrl.legal   = 1'b1;
        ctrl.crossed = 1'b1;
        ctrl.frac    = 1'b1;
        ctrl.sat     = code[1];
      end
      OPC_XF_SUB, OPC_XFS_SUB: begin
        ctrl.legal   = 1'b1;
        ctrl.crossed = 1'b1;
        ctrl.frac    = 1'b1;
        ctrl.sat     = code[1];
        ctrl.neg_lo  = 1'b1;
        ctrl.neg_hi  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/dotacc_lanes.sv
module dotacc_lanes
  import dotacc_pkg::*;
(
  input  logic [WORD_W-1:0]        src_a,
  input  logic [WORD_W-1:0]        src_b,
  input  logic                     crossed,
  input  logic                     frac,
  output lane_prod_t [LANES-1:0]   prods
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int PARTNER = LANES - 1 - l;
    logic [LANE_W-1:0] x_lane;
    logic [LANE_W-1:0] y_lane;
    assign x_lane = src_a[l*LANE_W +: LANE_W];
    assign y_lane = crossed ? src_b[PARTNER*LANE_W +: LANE_W]
                            : src_b[l*LANE_W +: LANE_W];
    assign prods[l] = lane_mul(x_lane, y_lane, frac);
  end
endmodule

// File: rtl/dotacc_combine.sv
module dotacc_combine
  import dotacc_pkg::*;
(
  input  logic [ACC_W-1:0]       acc_in,
  input  lane_prod_t [LANES-1:0] prods,
  input  ctrl_t                  ctrl,
  output logic [ACC_W-1:0]       acc_out,
  output logic                   pin_evt,
  output logic                   clip_evt
);
  logic [ACC_W-1:0] step0;
  logic [ACC_W-1:0] step1;
  clamp_t           clamped;

  // Lane 0 first, then lane 1, then the optional clamp.
  assign step0   = apply_prod(acc_in, prods[0].value, ctrl.neg_lo);
  assign step1   = apply_prod(step0,  prods[1].value, ctrl.neg_hi);
  assign clamped = clamp_word(step1);

  assign acc_out  = ctrl.sat ? clamped.value : step1;
  assign clip_evt = ctrl.sat & clamped.clipped;
  assign pin_evt  = prods[0].pinned | prods[1].pinned;
endmodule

// File: rtl/dotacc_bank.sv
module dotacc_bank
  import dotacc_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = $clog2(NUM_ACC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ACC-1:0]       op_wr,
  input  logic [ACC_W-1:0]         op_data,
  input  logic                     ovf_evt,
  input  logic                     tw_en,
  input  logic [IDX_W-1:0]         tw_sel,
  input  logic [ACC_W-1:0]         tw_data,
  output logic [NUM_ACC*ACC_W-1:0] acc_flat,
  output logic [NUM_ACC-1:0]       flags,
  output logic [NUM_ACC-1:0]       acc_wr
);
  for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
    logic [ACC_W-1:0] acc_q;
    logic             tw_hit;
    assign tw_hit    = tw_en && (int'(tw_sel) == k);
    assign acc_wr[k] = tw_hit | op_wr[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q    <= '0;
        flags[k] <= 1'b0;
      end else begin
        if (tw_hit)         acc_q <= tw_data;
        else if (op_wr[k])  acc_q <= op_data;
        if (op_wr[k] && ovf_evt) flags[k] <= 1'b1;
      end
    end
    assign acc_flat[k*ACC_W +: ACC_W] = acc_q;
  end
endmodule

// File: rtl/dotacc_unit.sv
module dotacc_unit
  import dotacc_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = $clog2(NUM_ACC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [CODE_W-1:0]   op_code,
  input  logic [IDX_W-1:0]    acc_sel,
  input  logic [WORD_W-1:0]   src_a,
  input  logic [WORD_W-1:0]   src_b,
  input  logic                tw_en,
  input  logic [IDX_W-1:0]    tw_sel,
  input  logic [ACC_W-1:0]    tw_data,
  input  logic [IDX_W-1:0]    tr_sel,
  output logic [ACC_W-1:0]    tr_data,
  output logic [NUM_ACC-1:0]  ovf_flags
);
  ctrl_t                    dec_ctrl;
  lane_prod_t [LANES-1:0]   prods;
  logic [NUM_ACC*ACC_W-1:0] acc_flat;
  logic [ACC_W-1:0]         cur_acc;
  logic [ACC_W-1:0]         next_acc;
  logic                     pin_evt;
  logic                     clip_evt;
  logic                     ovf_evt;
  logic                     op_fire;
  logic [NUM_ACC-1:0]       op_wr;
  logic [NUM_ACC-1:0]       acc_wr;

  dotacc_decode u_decode (
    .code (op_code),
    .ctrl (dec_ctrl)
  );

  dotacc_lanes u_lanes (
    .src_a   (src_a),
    .src_b   (src_b),
    .crossed (dec_ctrl.crossed),
    .frac    (dec_ctrl.frac),
    .prods   (prods)
  );

  assign cur_acc = acc_flat[int'(acc_sel)*ACC_W +: ACC_W];

  dotacc_combine u_combine (
    .acc_in   (cur_acc),
    .prods    (prods),
    .ctrl     (dec_ctrl),
    .acc_out  (next_acc),
    .pin_evt  (pin_evt),
    .clip_evt (clip_evt)
  );

  assign ovf_evt = pin_evt | clip_evt;
  assign op_fire = op_valid & dec_ctrl.legal & ~tw_en;

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_sel
    assign op_wr[k] = op_fire && (int'(acc_sel) == k);
  end

  dotacc_bank #(.NUM_ACC(NUM_ACC), .IDX_W(IDX_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_wr    (op_wr),
    .op_data  (next_acc),
    .ovf_evt  (ovf_evt),
    .tw_en    (tw_en),
    .tw_sel   (tw_sel),
    .tw_data  (tw_data),
    .acc_flat (acc_flat),
    .flags    (ovf_flags),
    .acc_wr   (acc_wr)
  );

  assign tr_data = acc_flat[int'(tr_sel)*ACC_W +: ACC_W];
endmodule

// File: rtl/dotacc_checks.sv
module dotacc_checks
  import dotacc_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = $clog2(NUM_ACC)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     op_valid,
  input logic                     legal,
  input logic                     sat_mode,
  input logic                     tw_en,
  input logic [IDX_W-1:0]         acc_sel,
  input logic [NUM_ACC-1:0]       op_wr,
  input logic [NUM_ACC-1:0]       acc_wr,
  input logic [NUM_ACC*ACC_W-1:0] acc_flat,
  input logic [NUM_ACC-1:0]       ovf_flags
);
  logic             sat_q;
  logic [IDX_W-1:0] sel_q;
  logic [ACC_W-1:0] sat_slice;
  logic             in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sat_q <= 1'b0;
      sel_q <= '0;
    end else begin
      sat_q <= (|op_wr) & sat_mode;
      sel_q <= acc_sel;
    end
  end

  assign sat_slice = acc_flat[int'(sel_q)*ACC_W +: ACC_W];
  assign in_range  = (&sat_slice[ACC_W-1:SAT_W-1]) | ~(|sat_slice[ACC_W-1:SAT_W-1]);

  p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_wr));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr == '0) |=> $stable(acc_flat));

  p_unlisted_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !legal) |-> (op_wr == '0));

  p_test_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tw_en |-> (op_wr == '0));

  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flags != '0) |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

  p_flags_need_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr == '0) |=> $stable(ovf_flags));

  p_clamp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_q |-> in_range);
endmodule

bind dotacc_unit dotacc_checks #(.NUM_ACC(NUM_ACC), .IDX_W(IDX_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .legal     (dec_ctrl.legal),
  .sat_mode  (dec_ctrl.sat),
  .tw_en     (tw_en),
  .acc_sel   (acc_sel),
  .op_wr     (op_wr),
  .acc_wr    (acc_wr),
  .acc_flat  (acc_flat),
  .ovf_flags (ovf_flags)
);

// File: tb/dotacc_unit_test.sv
module dotacc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [1:0]  acc_sel = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        tw_en = 1'b0;
  logic [1:0]  tw_sel = '0;
  logic [63:0] tw_data = '0;
  logic [1:0]  tr_sel = '0;
  logic [63:0] tr_data;
  logic [3:0]  ovf_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_flags = '0;

  always #4 clk = ~clk;

  dotacc_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .src_a(src_a), .src_b(src_b), .tw_en(tw_en),
    .tw_sel(tw_sel), .tw_data(tw_data), .tr_sel(tr_sel), .tr_data(tr_data),
    .ovf_flags(ovf_flags)
  );

  typedef struct packed {
    logic [4:0]  code;
    logic [1:0]  sel;
    logic [31:0] a;
    logic [31:0] b;
    logic [63:0] init;
    logic [63:0] expv;
    logic        flg;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{5'b00000, 2'd0, 32'h0003_0002, 32'h0005_0004, 64'h0, 64'h17, 1'b0},
    '{5'b00001, 2'd1, 32'h0003_0002, 32'h0005_0004, 64'h64, 64'h4D, 1'b0},
    '{5'b00000, 2'd2, 32'hFFFF_FFFE, 32'h0003_0004, 64'h0, 64'hFFFF_FFFF_FFFF_FFF5, 1'b0},
    '{5'b01000, 2'd3, 32'h0003_0002, 32'h0005_0004, 64'h0, 64'h16, 1'b0},
    '{5'b01001, 2'd0, 32'h0003_0002, 32'h0005_0004, 64'h1000, 64'hFEA, 1'b0},
    '{5'b00010, 2'd1, 32'h0003_0002, 32'h0005_0004, 64'h0, 64'h7, 1'b0},
    '{5'b11000, 2'd2, 32'h4000_2000, 32'h1000_0800, 64'h0, 64'h0800_0000, 1'b0},
    '{5'b11001, 2'd3, 32'h4000_2000, 32'h1000_0800, 64'h0, 64'hFFFF_FFFF_F800_0000, 1'b0},
    '{5'b11000, 2'd0, 32'h0001_8000, 32'h8000_0001, 64'h0, 64'h8000_0001, 1'b1},
    '{5'b11010, 2'd1, 32'h4000_4000, 32'h4000_4000, 64'h7FFF_0000, 64'h7FFF_FFFF, 1'b1},
    '{5'b11011, 2'd2, 32'h4000_4000, 32'h4000_4000, 64'hFFFF_FFFF_8000_1000, 64'hFFFF_FFFF_8000_0000, 1'b1},
    '{5'b11010, 2'd3, 32'h0002_0003, 32'h0004_0005, 64'h10, 64'h3C, 1'b0},
    '{5'b11011, 2'd3, 32'h0002_0003, 32'h0004_0005, 64'h3C, 64'h10, 1'b0},
    '{5'b00000, 2'd3, 32'h0000_0001, 32'h0000_0001, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0},
    '{5'b11000, 2'd3, 32'h4000_4000, 32'h4000_4000, 64'h7FFF_FFF0, 64'hBFFF_FFF0, 1'b0},
    '{5'b00011, 2'd1, 32'h0003_0002, 32'h0005_0004, 64'h55, 64'h55, 1'b0}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1, 2:     return "R2";
      3, 4:        return "R3";
      5:           return "R4";
      6, 7:        return "R5";
      8:           return "R6";
      9, 10, 11, 12: return "R7";
      13, 14:      return "R9";
      default:     return "R10";
    endcase
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic test_write(input logic [1:0] sel, input logic [63:0] data);
    @(negedge clk);
    tw_en = 1'b1; tw_sel = sel; tw_data = data;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic issue(input logic [4:0] code, input logic [1:0] sel,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; acc_sel = sel; src_a = a; src_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic read_acc(input logic [1:0] sel, output logic [63:0] v);
    tr_sel = sel;
    #1;
    v = tr_data;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    logic [63:0] v;
    for (int k = 0; k < 4; k++) begin
      read_acc(k[1:0], v);
      check64("R1 accumulator after reset", v, 64'h0);
    end
    check64("R1 flags after reset", {60'h0, ovf_flags}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    // Table walk: preload accumulator, run one operation, read back.
    for (int i = 0; i < NV; i++) begin
      test_write(VECS[i].sel, VECS[i].init);
      issue(VECS[i].code, VECS[i].sel, VECS[i].a, VECS[i].b);
      read_acc(VECS[i].sel, v);
      check64(row_tag(i), v, VECS[i].expv);
      if (VECS[i].flg) exp_flags[VECS[i].sel] = 1'b1;
      check64("R8 flag vector", {60'h0, ovf_flags}, {60'h0, exp_flags});
    end

    // R12: only the selected accumulator moves.
    test_write(2'd0, 64'h100);
    test_write(2'd1, 64'h200);
    test_write(2'd2, 64'h300);
    test_write(2'd3, 64'h400);
    issue(5'b00000, 2'd1, 32'h0001_0001, 32'h0001_0001);
    read_acc(2'd1, v); check64("R12 target", v, 64'h202);
    read_acc(2'd0, v); check64("R12 other acc0", v, 64'h100);
    read_acc(2'd2, v); check64("R12 other acc2", v, 64'h300);
    read_acc(2'd3, v); check64("R12 other acc3", v, 64'h400);

    // R11: test write and operation in the same cycle; the operation is dropped.
    @(negedge clk);
    tw_en = 1'b1; tw_sel = 2'd2; tw_data = 64'h1234;
    op_valid = 1'b1; op_code = 5'b11010; acc_sel = 2'd2;
    src_a = 32'h8000_8000; src_b = 32'h8000_8000;
    @(negedge clk);
    tw_en = 1'b0; op_valid = 1'b0;
    read_acc(2'd2, v); check64("R11 test write wins", v, 64'h1234);
    check64("R11 flags untouched", {60'h0, ovf_flags}, {60'h0, exp_flags});

    // R6: both crossed pairs are -1 * -1, on a clean accumulator.
    test_write(2'd3, 64'h0);
    issue(5'b11000, 2'd3, 32'h8000_8000, 32'h8000_8000);
    read_acc(2'd3, v); check64("R6 both lanes pinned", v, 64'h0000_0000_FFFF_FFFE);
    exp_flags[3] = 1'b1;
    check64("R6 flag set", {60'h0, ovf_flags}, {60'h0, exp_flags});

    // R1: reset mid-run clears everything.
    pulse_reset();
    check_reset_state();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule